// File: doc/BRIEF.md
# Shadow Memory Attribute Controller

This block keeps the configuration that decides, for each 16 KB piece of the upper memory window from C0000h to FFFFFh, whether a processor read is served from on-board DRAM or from the expansion bus. It also decides the same for writes. Software programs four byte-wide registers through a small address/data port. A memory controller presents a 20-bit physical address and gets back two routing flags for that location: `read_internal` and `write_internal`.

One global register holds a single read policy and a single write policy. Three enable registers turn that policy on, segment by segment, for the C, D and E areas. The top 64 KB area, F0000h to FFFFFh, always follows the global policy. A segment that is not enabled, and any address below C0000h, always goes to the expansion bus. The write policy can only be internal when reads are internal too.

The register port and the routing flags are plain control signals with no handshake. A register write takes effect at the next rising clock edge. The flags are combinational from the address and the stored configuration.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset, all four registers (address 0 global policy, 1 C-area enables, 2 D-area enables, 3 E-area enables) read back as 00h.
- R2: `cfg_rdata` shows the full byte last written to the register selected by `cfg_addr`, all eight bits included.
- R3: When global bit 6 is 1, reads in an active segment route internal (`read_internal`=1). When global bit 6 is 0, they route external.
- R4: When global bit 6 is 1, global bit 5 = 1 makes writes in an active segment external, and bit 5 = 0 makes them internal.
- R5: When global bit 6 is 0, `write_internal` is 0 whatever the value of bit 5.
- R6: Addresses F0000h–FFFFFh are always active and take the global policy with no enable bit.
- R7: Register 1 covers C0000h, register 2 covers D0000h and register 3 covers E0000h. Within each, bit 7 enables the lowest 16 KB segment, and bits 6, 5 and 4 enable the next three segments upward.
- R8: In a segment whose enable bit is 0, both flags are 0.
- R9: Any address below C0000h gives both flags 0.
- R10: Bits 3..0 of the enable registers have no effect on routing.
- R11: A register write changes the flags from the cycle after the write edge. In the cycle where the write is presented, the flags still follow the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Contents of the selected register |
| mem_addr | input | 20 | Physical address being routed |
| read_internal | output | 1 | 1: read from DRAM, 0: read from expansion bus |
| write_internal | output | 1 | 1: write to DRAM, 0: write to expansion bus |

## Verification
Some rules hold on every cycle without knowing the configuration, and the assertions check those. An internal write never appears without an internal read. Addresses below the window never route internal. A register reads back what was written to it. The flags hold steady when neither the address nor the configuration changes. The link from each enable bit to its segment, the policy decode for each of the four bit 6/bit 5 combinations, the independence of the F area from the enables, the unused low enable bits, and the one-cycle update timing can only be shown by the bench. It sweeps every segment under each policy and compares the flags against its own reference model.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // Register map of the configuration port
  typedef enum logic [1:0] {
    REG_POLICY = 2'd0,
    REG_EN_C   = 2'd1,
    REG_EN_D   = 2'd2,
    REG_EN_E   = 2'd3
  } shadow_reg_e;

  // Bit positions inside the global policy register
  localparam int POL_RD_BIT = 6;
  localparam int POL_WR_BIT = 5;

  typedef struct packed {
    logic rd_int;
    logic wr_int;
  } route_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int N_REGS = 4,
  localparam int RA_W = $clog2(N_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [RA_W-1:0]                addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [N_REGS-1:0][DATA_W-1:0]  regs_q
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[r] <= '0;
      else if (wr_en && (addr == RA_W'(r)))
        regs_q[r] <= wdata;
    end
  end

  assign rdata = regs_q[addr];
endmodule

// File: rtl/shadow_policy.sv
module shadow_policy (
  input  logic                 rd_sel,
  input  logic                 wr_ext_sel,
  output shadow_pkg::route_t   pol
);
  // Writes may only go internal while reads are internal
  always_comb begin
    pol.rd_int = rd_sel;
    pol.wr_int = rd_sel & ~wr_ext_sel;
  end
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 8,
  parameter int N_EN_AREAS   = 3,
  parameter int SEG_PER_AREA = 4,
  localparam int SEG_W    = $clog2(SEG_PER_AREA),
  localparam int AREA_W   = $clog2(N_EN_AREAS + 1),
  localparam int SEG_LSB  = ADDR_W - 2 - AREA_W - SEG_W,
  localparam int AREA_LSB = SEG_LSB + SEG_W,
  localparam int TOP_LSB  = AREA_LSB + AREA_W,
  localparam int N_SEGS   = N_EN_AREAS * SEG_PER_AREA
) (
  input  logic [ADDR_W-1:SEG_LSB]               addr_hi,
  input  logic [N_EN_AREAS-1:0][DATA_W-1:0]     en_regs,
  input  shadow_pkg::route_t                    pol,
  output logic                                  read_internal,
  output logic                                  write_internal
);
  logic [N_SEGS-1:0] seg_en;
  logic [N_EN_AREAS-1:0][DATA_W-SEG_PER_AREA-1:0] unused_low_bits;

  // Highest bit of each enable register maps to the lowest segment
  for (genvar a = 0; a < N_EN_AREAS; a++) begin : g_area
    for (genvar s = 0; s < SEG_PER_AREA; s++) begin : g_seg
      assign seg_en[a*SEG_PER_AREA + s] = en_regs[a][DATA_W-1-s];
    end
    assign unused_low_bits[a] = en_regs[a][DATA_W-SEG_PER_AREA-1:0];
  end

  logic              in_window;
  logic [AREA_W-1:0] area;
  logic [SEG_W-1:0]  seg;
  logic              active;

  assign in_window = &addr_hi[ADDR_W-1:TOP_LSB];
  assign area      = addr_hi[TOP_LSB-1:AREA_LSB];
  assign seg       = addr_hi[AREA_LSB-1:SEG_LSB];

  always_comb begin
    active = 1'b0;
    if (area == AREA_W'(N_EN_AREAS)) begin
      active = 1'b1;
    end else begin
      for (int a = 0; a < N_EN_AREAS; a++) begin
        for (int s = 0; s < SEG_PER_AREA; s++) begin
          if ((area == AREA_W'(a)) && (seg == SEG_W'(s)))
            active = seg_en[a*SEG_PER_AREA + s];
        end
      end
    end
  end

  assign read_internal  = in_window & active & pol.rd_int;
  assign write_internal = in_window & active & pol.wr_int;
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl #(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 8,
  parameter int N_EN_AREAS   = 3,
  parameter int SEG_PER_AREA = 4,
  localparam int N_REGS  = N_EN_AREAS + 1,
  localparam int RA_W    = $clog2(N_REGS),
  localparam int SEG_LSB = ADDR_W - 2 - $clog2(N_EN_AREAS + 1) - $clog2(SEG_PER_AREA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              read_internal,
  output logic              write_internal
);
  import shadow_pkg::*;

  logic [N_REGS-1:0][DATA_W-1:0] cfg_q;
  route_t                        pol;
  logic                          unused_addr_lo;

  assign unused_addr_lo = ^mem_addr[SEG_LSB-1:0];

  shadow_cfg_regs #(.DATA_W(DATA_W), .N_REGS(N_REGS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .regs_q (cfg_q)
  );

  shadow_policy u_pol (
    .rd_sel     (cfg_q[REG_POLICY][POL_RD_BIT]),
    .wr_ext_sel (cfg_q[REG_POLICY][POL_WR_BIT]),
    .pol        (pol)
  );

  shadow_seg_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .N_EN_AREAS(N_EN_AREAS), .SEG_PER_AREA(SEG_PER_AREA)
  ) u_dec (
    .addr_hi        (mem_addr[ADDR_W-1:SEG_LSB]),
    .en_regs        (cfg_q[N_REGS-1:1]),
    .pol            (pol),
    .read_internal  (read_internal),
    .write_internal (write_internal)
  );
endmodule

// File: rtl/shadow_attr_ctrl_chk.sv
module shadow_attr_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [1:0]        cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              read_internal,
  input logic              write_internal
);
  // R5
  wr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_internal |-> read_internal);

  // R9
  below_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1:ADDR_W-2] != 2'b11) |-> (!read_internal && !write_internal));

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> ((cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata))));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> (!$stable(mem_addr) ||
                    ($stable(read_internal) && $stable(write_internal))));
endmodule

bind shadow_attr_ctrl shadow_attr_ctrl_chk u_chk (.*);

// File: tb/shadow_attr_ctrl_tb.sv
module shadow_attr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic [19:0] mem_addr = 20'h0;
  logic        read_internal, write_internal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected item: [8] kind (1 = register read, 0 = flags), [7:0] value
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_reg[4];

  always #10 clk = ~clk;

  shadow_attr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .read_internal(read_internal), .write_internal(write_internal)
  );

  // Reference model of the routing rules
  function automatic logic [1:0] ref_flags(input logic [19:0] a);
    logic on, rd, wr;
    int area, seg;
    if (a < 20'hC0000) return 2'b00;
    area = int'((a - 20'hC0000) >> 16);
    seg  = int'(a[15:14]);
    on   = (area == 3) ? 1'b1 : m_reg[area + 1][7 - seg];
    rd   = m_reg[0][6];
    wr   = m_reg[0][6] && !m_reg[0][5];
    return {on && rd, on && wr};
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    m_reg[a] = d;
  endtask

  task automatic drv_flags(input logic [19:0] a, input string tag);
    @(posedge clk); #1;
    mem_addr = a;
    exp_q.push_back({1'b0, 6'd0, ref_flags(a)});
    tag_q.push_back(tag);
  endtask

  task automatic drv_read(input logic [1:0] a, input string tag);
    @(posedge clk); #1;
    cfg_addr = a;
    exp_q.push_back({1'b1, m_reg[a]});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        string      t;
        logic [7:0] got;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = e[8] ? cfg_rdata : {6'd0, read_internal, write_internal};
        checks++;
        if (got !== e[7:0]) begin
          fails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, mem_addr, got, e[7:0]);
        end
      end
    end
  end

  // Sweep every segment of C0000h..FFFFFh plus addresses below the window
  task automatic sweep(input string tag);
    drv_flags(20'h00000, {tag, " R9"});
    drv_flags(20'hBFFFF, {tag, " R9"});
    for (int i = 0; i < 16; i++) begin
      logic [19:0] base;
      base = 20'hC0000 + 20'(i) * 20'h4000;
      drv_flags(base, {tag, (i >= 12) ? " R6" : " R7/R8"});
      drv_flags(base + 20'h3FFF, {tag, (i >= 12) ? " R6" : " R7/R8"});
    end
  endtask

  initial begin
    for (int r = 0; r < 4; r++) m_reg[r] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    for (int r = 0; r < 4; r++) drv_read(2'(r), "R1 reset");
    sweep("R1 reset");

    // R3 R4 R5 R10: all four policy combinations, two enable patterns
    for (int p = 0; p < 4; p++) begin
      cfg_write(2'd0, {1'b0, p[1], p[0], 5'b10101});
      cfg_write(2'd1, 8'h8F);   // low bits set: R10
      cfg_write(2'd2, 8'h50);
      cfg_write(2'd3, 8'h30);
      sweep("R3/R4/R5/R10 setA");
      cfg_write(2'd1, 8'h70);
      cfg_write(2'd2, 8'hA0);
      cfg_write(2'd3, 8'hCF);
      sweep("R3/R4/R5 setB");
    end

    // R2: full-byte readback
    cfg_write(2'd0, 8'hFF);
    cfg_write(2'd2, 8'h5A);
    for (int r = 0; r < 4; r++) drv_read(2'(r), "R2 readback");

    // R11: flags change only after the write edge
    cfg_write(2'd0, 8'h40);
    cfg_write(2'd3, 8'h00);
    drv_flags(20'hE0000, "R11 before");
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_addr = 2'd3; cfg_wdata = 8'h80;
    exp_q.push_back({1'b0, 8'h00});   // same cycle: old configuration
    tag_q.push_back("R11 write cycle");
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    m_reg[3] = 8'h80;
    exp_q.push_back({1'b0, 6'd0, 2'b11});
    tag_q.push_back("R11 next cycle");

    repeat (4) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule